// File: doc/BRIEF.md
# Dual-Law SPI Serial-Clock Divider

This block turns a fast module clock into the edge-rate strobe that a serial transfer engine uses to toggle its SPI clock line. Software writes one 13-bit clock control word. The word holds an 8-bit linear divisor, a 4-bit power-of-two exponent and a select bit that picks which of the two divide laws is in force. The block raises a single-cycle strobe at twice the wanted SCK rate. The engine flips SCK on every strobe, so one SCK period spans two strobe intervals.

A write to the control word can arrive at any time. The divider only reads it while no burst runs. While the burst-active input is high, the working copy of the settings stays frozen, so a burst never sees a clipped or stretched interval. The divide counter is held at zero between bursts. Each burst therefore places its first strobe at a fixed distance from its start.

With the linear law the SCK frequency is the module clock divided by 2×(L+1). With the exponential law it is the module clock divided by 2^(E+1). Software chooses the law and the values that fit the wanted rate.

Top module: `spi_ckdiv`

## Requirements
- R1: After synchronous reset the strobe is low and the control word is all zeros. A burst started before any write therefore uses the exponential law with exponent 0 and strobes on every cycle.
- R2: When bit 12 of the control word is 1, the strobe interval is L+1 module clocks, where L is bits 7:0.
- R3: When bit 12 is 0, the strobe interval is 2^E module clocks, where E is bits 11:8.
- R4: The same L and E fields give different intervals when only bit 12 changes. The field that is not selected has no effect.
- R5: Counting the rising edges at which burst-active is sampled high, the strobe is high after edge n exactly when n is a multiple of the interval. The first strobe therefore follows edge P, where P is the interval.
- R6: While burst-active is low, and in the cycle after it is first sampled low, the strobe stays low, whatever the control word holds.
- R7: A control word written while a burst runs does not alter that burst's interval. The new word takes effect on the next burst, provided it was written at least two cycles before that burst starts.
- R8: Each strobe is one cycle wide whenever the interval is greater than one.
- R9: A burst that stops mid-interval leaves no residue. The next burst counts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the clock control word |
| ctl_wdata | input | 13 | Control word: [12] law select, [11:8] exponent, [7:0] linear divisor |
| burst_en | input | 1 | High for the whole duration of a transfer burst |
| sck_tick | output | 1 | One-cycle strobe, high at twice the SCK rate |

## Verification
A control-word write and the running count can fall in the same cycle when a write lands in the middle of an active burst. The bench provokes this by writing a word with a different law and interval part-way through a burst. It then keeps checking every remaining cycle of that burst against the old interval, and checks the following burst against the new one. A burst stop in the middle of an interval, followed at once by a restart, is judged by requiring the restarted burst's strobe pattern to line up with its own start.

// File: rtl/spi_ckdiv_pkg.sv
// Package: spi_ckdiv_pkg
// Shared widths, control-word layout and law encoding for the serial clock
// divider. Assumes the control word is packed as {select, exponent, linear}.
package spi_ckdiv_pkg;

    localparam int CKD_LIN_W = 8;
    localparam int CKD_EXP_W = 4;
    localparam int CKD_CFG_W = CKD_LIN_W + CKD_EXP_W + 1;
    // Widest terminal count: 2^(2^EXP_W - 1) - 1 or 2^LIN_W - 1.
    localparam int CKD_EXP_CNT_W = (1 << CKD_EXP_W) - 1;
    localparam int CKD_CNT_W = (CKD_EXP_CNT_W > CKD_LIN_W) ? CKD_EXP_CNT_W : CKD_LIN_W;

    typedef enum logic {
        LAW_POW2   = 1'b0,
        LAW_LINEAR = 1'b1
    } ckd_law_e;

    typedef struct packed {
        ckd_law_e               law;
        logic [CKD_EXP_W-1:0]   expo;
        logic [CKD_LIN_W-1:0]   lin;
    } ckd_cfg_t;

endpackage

// File: rtl/spi_ckdiv_regs.sv
// Module: spi_ckdiv_regs
// Holds the software-visible control word and a working copy used by the
// counter. The working copy follows the control word only while no burst
// runs, so settings never change inside a burst.
// Assumes: ctl_we may pulse at any time; burst_en is synchronous to clk.
module spi_ckdiv_regs
    import spi_ckdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctl_we,
    input  ckd_cfg_t ctl_wdata,
    input  logic     burst_en,
    output ckd_cfg_t work_cfg
);

    ckd_cfg_t ctl_q;
    ckd_cfg_t work_q;

    // Capture a software write into the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= ctl_wdata;
        end
    end

    // Refresh the working copy only between bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
        end else if (!burst_en) begin
            work_q <= ctl_q;
        end
    end

    assign work_cfg = work_q;

endmodule

// File: rtl/spi_ckdiv_law.sv
// Module: spi_ckdiv_law
// Turns the working settings into a terminal count (interval minus one)
// under either the linear law or the power-of-two law.
// Assumes: CNT_W is wide enough for 2^(2^EXP_W - 1) - 1 and for 2^LIN_W - 1.
module spi_ckdiv_law
    import spi_ckdiv_pkg::*;
#(
    parameter int LIN_W = CKD_LIN_W,
    parameter int EXP_W = CKD_EXP_W,
    parameter int CNT_W = CKD_CNT_W
) (
    input  logic             law_linear,
    input  logic [LIN_W-1:0] lin_div,
    input  logic [EXP_W-1:0] exp_div,
    output logic [CNT_W-1:0] term
);

    localparam int SHIFT_W = CNT_W + 1;

    logic [CNT_W-1:0]   lin_term;
    logic [SHIFT_W-1:0] pow_span;
    logic [CNT_W-1:0]   pow_term;

    // Linear law: the interval is lin_div + 1, so the terminal count is lin_div.
    generate
        if (CNT_W > LIN_W) begin : g_lin_pad
            assign lin_term = {{(CNT_W-LIN_W){1'b0}}, lin_div};
        end else begin : g_lin_fit
            assign lin_term = lin_div[CNT_W-1:0];
        end
    endgenerate

    // Power-of-two law: the interval is 2^exp_div, so the terminal count is that minus one.
    always_comb begin
        pow_span = SHIFT_W'(1) << exp_div;
        pow_term = CNT_W'(pow_span - SHIFT_W'(1));
    end

    // Pick the law requested by the select bit.
    always_comb begin
        term = law_linear ? lin_term : pow_term;
    end

endmodule

// File: rtl/spi_ckdiv_count.sv
// Module: spi_ckdiv_count
// Divide counter and strobe register. The counter is held at zero while no
// burst runs, climbs to the terminal count, then wraps and raises a one-cycle
// strobe.
// Assumes: term is stable for the whole of a burst.
module spi_ckdiv_count #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] term,
    output logic [CNT_W-1:0] cnt,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;
    logic             tick_q;
    logic             at_term;

    // Compare the count against the end of the interval.
    always_comb begin
        at_term = (cnt_q == term);
    end

    // Advance the count during a burst; clear it at the wrap and while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || at_term) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Register the strobe when the count wraps inside a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= run && at_term;
        end
    end

    assign cnt  = cnt_q;
    assign tick = tick_q;

endmodule

// File: rtl/spi_ckdiv.sv
// Module: spi_ckdiv
// Top of the dual-law serial clock divider. It holds the control word,
// freezes a working copy while a burst runs, works out the terminal count
// and drives the edge strobe for the transfer engine.
// Assumes: burst_en is synchronous to clk; the engine toggles SCK per strobe.
module spi_ckdiv
    import spi_ckdiv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_we,
    input  logic [CKD_CFG_W-1:0] ctl_wdata,
    input  logic                 burst_en,
    output logic                 sck_tick
);

    ckd_cfg_t               work_cfg;
    logic [CKD_CNT_W-1:0]   term_w;
    logic [CKD_CNT_W-1:0]   cnt_w;

    // Control word and burst-frozen working copy.
    spi_ckdiv_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ckd_cfg_t'(ctl_wdata)),
        .burst_en  (burst_en),
        .work_cfg  (work_cfg)
    );

    // Terminal count from the selected law.
    spi_ckdiv_law #(
        .LIN_W (CKD_LIN_W),
        .EXP_W (CKD_EXP_W),
        .CNT_W (CKD_CNT_W)
    ) u_law (
        .law_linear (work_cfg.law == LAW_LINEAR),
        .lin_div    (work_cfg.lin),
        .exp_div    (work_cfg.expo),
        .term       (term_w)
    );

    // Divide counter and strobe.
    spi_ckdiv_count #(
        .CNT_W (CKD_CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (burst_en),
        .term  (term_w),
        .cnt   (cnt_w),
        .tick  (sck_tick)
    );

endmodule

// File: rtl/spi_ckdiv_chk.sv
// Module: spi_ckdiv_chk
// Property checker for spi_ckdiv, bound to every instance of the top.
module spi_ckdiv_chk #(
    parameter int CNT_W = 15,
    parameter int CFG_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             burst_en,
    input logic             sck_tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] term,
    input logic [CFG_W-1:0] work
);

    // R1: reset clears the strobe.
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !sck_tick);

    // R6: no strobe follows an idle sample.
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_en |=> !sck_tick);

    // R7: working settings hold while a burst continues.
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_en && $past(burst_en)) |-> $stable(work));

    // R8: a strobe lasts one cycle when the interval exceeds one.
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_tick && term != '0 && burst_en) |=> !sck_tick);

    // R9: each burst starts counting from zero.
    a_r9_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_en) |-> (cnt == '0));

    // R5: the count never passes the end of the interval during a burst.
    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        burst_en |-> (cnt <= term));

endmodule

bind spi_ckdiv spi_ckdiv_chk #(
    .CNT_W (spi_ckdiv_pkg::CKD_CNT_W),
    .CFG_W (spi_ckdiv_pkg::CKD_CFG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .burst_en (burst_en),
    .sck_tick (sck_tick),
    .cnt      (cnt_w),
    .term     (term_w),
    .work     (work_cfg)
);

// File: tb/spi_ckdiv_bench.sv
// Directed bench for spi_ckdiv: one task per scenario, each checking itself.
module spi_ckdiv_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [12:0] ctl_wdata = '0;
    logic        burst_en = 1'b0;
    logic        sck_tick;

    int checks = 0;
    int failures = 0;
    int idx = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_ckdiv u_spi_ckdiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .burst_en  (burst_en),
        .sck_tick  (sck_tick)
    );

    function automatic logic [12:0] word(input bit lin_law, input int e, input int l);
        return {lin_law, 4'(e), 8'(l)};
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic write_cfg(input logic [12:0] w);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic start_burst();
        @(negedge clk);
        burst_en = 1'b1;
        idx = 0;
    endtask

    // Follow n edges of a running burst; count cycles whose strobe breaks interval p.
    task automatic watch(input int p, input int n, input string req);
        int bad = 0;
        int first_bad = -1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            ctl_we = 1'b0;
            idx++;
            if (sck_tick !== ((idx % p) == 0)) begin
                bad++;
                if (first_bad < 0) first_bad = idx;
            end
        end
        check({req, " mismatching strobe cycles"}, bad, 0);
        if (bad != 0) $display("  first mismatch at burst edge %0d, interval %0d", first_bad, p);
    endtask

    task automatic stop_burst(input string req);
        int seen = 0;
        burst_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (sck_tick) seen++;
        end
        check({req, " strobes after burst stop"}, seen, 0);
    endtask

    task automatic t_reset();
        int seen = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 strobe in reset", int'(sck_tick), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (sck_tick) seen++;
        end
        check("R1 strobes idle after reset", seen, 0);
        start_burst();
        watch(1, 10, "R1 default word interval 1");
        stop_burst("R6");
    endtask

    task automatic t_linear();
        write_cfg(word(1'b1, 9, 5));
        start_burst();
        watch(6, 36, "R2 linear L=5");
        stop_burst("R6");
        write_cfg(word(1'b1, 0, 0));
        start_burst();
        watch(1, 8, "R2 linear L=0");
        stop_burst("R6");
        write_cfg(word(1'b1, 15, 255));
        start_burst();
        watch(256, 512, "R2 linear L=255");
        stop_burst("R6");
    endtask

    task automatic t_pow2();
        write_cfg(word(1'b0, 3, 200));
        start_burst();
        watch(8, 40, "R3 pow2 E=3");
        stop_burst("R6");
        write_cfg(word(1'b0, 15, 7));
        start_burst();
        watch(32768, 65536, "R3 pow2 E=15");
        stop_burst("R6");
    endtask

    task automatic t_select();
        write_cfg(word(1'b1, 2, 2));
        start_burst();
        watch(3, 18, "R4 select linear");
        stop_burst("R6");
        write_cfg(word(1'b0, 2, 2));
        start_burst();
        watch(4, 16, "R4 select pow2");
        stop_burst("R6");
    endtask

    task automatic t_first_edge();
        write_cfg(word(1'b1, 0, 9));
        start_burst();
        watch(10, 10, "R5 first strobe at edge 10");
        stop_burst("R6");
    endtask

    task automatic t_idle_write();
        int seen = 0;
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = word(1'b1, 0, 0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            ctl_we = 1'b0;
            if (sck_tick) seen++;
        end
        check("R6 no strobe while idle after write", seen, 0);
    endtask

    task automatic t_mid_burst_write();
        write_cfg(word(1'b1, 0, 3));
        start_burst();
        watch(4, 10, "R7 before write");
        ctl_we = 1'b1;
        ctl_wdata = word(1'b0, 1, 0);
        watch(4, 30, "R7 after mid-burst write");
        stop_burst("R7");
        start_burst();
        watch(2, 12, "R7 next burst uses new word");
        stop_burst("R6");
    endtask

    task automatic t_restart();
        int seen = 0;
        write_cfg(word(1'b1, 0, 6));
        start_burst();
        watch(7, 11, "R9 partial burst");
        burst_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        if (sck_tick) seen++;
        check("R9 strobe in gap", seen, 0);
        start_burst();
        watch(7, 21, "R9 restarted burst R8");
        stop_burst("R6");
    endtask

    initial begin
        t_reset();
        t_linear();
        t_pow2();
        t_select();
        t_first_edge();
        t_idle_write();
        t_mid_burst_write();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule